// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block turns a vector of external interrupt request lines into delivery messages for a downstream interrupt fabric. Every pin owns a 64-bit redirection entry that sets the line's polarity, whether it triggers on edges or on levels, whether it is masked, and which message the pin sends: destination, destination mode, delivery mode and vector. The block keeps one pending bit per pin. It also tracks a remote-acknowledge flag for level pins, which blocks a second message until software signals end-of-interrupt for that vector.

A separate access block writes the entries through a single-entry write port and reads them back through a combinational read port. End-of-interrupt notices arrive with their vector on a one-cycle strobe. In pass-through mode the vector comes from an external-controller vector input and not from the entry. Messages leave through a valid/ready output register. Each cycle the engine serves the lowest-numbered pin that is ready to go.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset the pending register is all zero, no message is valid, and every entry reads back as 64'h0000_0000_0001_0000, which is masked with all other fields zero.
- R2: Entry fields sit at these positions: destination [63:56], mask [16], trigger [15] (0 edge, 1 level), remote-acknowledge [14], polarity [13], pending status [12], destination mode [11], delivery mode [10:8], vector [7:0]. Bits 14 and 12 and the unused bits ignore writes. Bit 14 reads the remote-acknowledge flag, bit 12 reads the pin's pending bit, and unused bits read zero. Write indices at or above the pin count are ignored.
- R3: Request input 0 drives pin 2. Input k for k ≥ 1 drives pin k. Inputs whose pin number is not below the pin count have no effect.
- R4: When the polarity bit is 1, the synchronised line is inverted before any trigger processing, so a falling line is a rising request.
- R5: An edge pin becomes pending on a rising active request only while unmasked. A request that arrives while the pin is masked is discarded and gives no message after a later unmask.
- R6: A level pin's pending bit follows its active level, and this holds while it is masked too. A masked, active level pin sends one message once it is unmasked. Releasing the line clears its pending bit.
- R7: A message carries the entry's destination, destination mode, delivery mode, vector and trigger bit.
- R8: For delivery mode 7 (pass-through) the message vector is the external-controller vector input and not the entry's vector field.
- R9: Loading a message clears an edge pin's pending bit, so a held edge line gives exactly one message. For a level pin it sets remote-acknowledge instead, and that pin sends no further message while the flag is set.
- R10: An end-of-interrupt notice clears remote-acknowledge on every entry whose flag is set and whose vector equals the notice vector. Such a pin, if still active and unmasked, sends again. A notice with a different vector changes nothing.
- R11: When several pins are eligible, the lowest-numbered one is loaded first, with at most one message per cycle.
- R12: While the message is valid and not ready, all message fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_INPUTS | Asynchronous interrupt request lines |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry write index |
| cfg_wdata | input | 64 | Entry write data |
| rd_idx | input | IDX_W | Entry read index |
| rd_data | output | 64 | Entry read data (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | End-of-interrupt vector |
| ext_vector | input | 8 | Vector from the external controller for pass-through mode |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the fabric |
| msg_dest | output | 8 | Message destination |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_deliv_mode | output | 3 | Message delivery mode |
| msg_vector | output | 8 | Message vector |
| msg_trig | output | 1 | Message trigger mode (1 level) |

## Verification
The main function is tested with these input patterns:
- A held edge line checks that only the edge counts.
- A masked edge followed by an unmask checks capture against discard.
- An inverted-polarity line that falls checks that the polarity bit is honoured.
- A masked, held level line that is then unmasked checks that pending is tracked while masked.
- Input 0 and the out-of-range inputs check the pin mapping.
- A level pin is taken through a non-matching and then a matching end-of-interrupt, both with the line still high and after the line drops, to separate the blocking flag from redelivery.
- Two edges on adjacent pins that arrive in the same cycle while the fabric stalls show both the serving order and that the message holds steady.

// File: rtl/irde_pkg.sv
package irde_pkg;

    localparam int ENTRY_W = 64;

    typedef enum logic [2:0] {
        DLV_FIXED  = 3'd0,
        DLV_LOWPRI = 3'd1,
        DLV_PMI    = 3'd2,
        DLV_NMI    = 3'd4,
        DLV_INIT   = 3'd5,
        DLV_SIPI   = 3'd6,
        DLV_PASS   = 3'd7
    } dlv_e;

    // Stored fields of one redirection entry (pending status lives elsewhere)
    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       racked;
        logic       inv;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
    } redir_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
        logic       level;
    } msg_t;

    localparam redir_t ENTRY_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                       racked: 1'b0, inv: 1'b0, dmode: 1'b0,
                                       dlv: 3'd0, vec: 8'h00};

    // Logical request line to pin number
    function automatic int unsigned line_to_pin(input int unsigned line);
        return (line == 0) ? 2 : line;
    endfunction

    function automatic logic [ENTRY_W-1:0] pack_entry(input redir_t e, input logic pend);
        logic [ENTRY_W-1:0] w;
        w        = '0;
        w[63:56] = e.dest;
        w[16]    = e.mask;
        w[15]    = e.level;
        w[14]    = e.racked;
        w[13]    = e.inv;
        w[12]    = pend;
        w[11]    = e.dmode;
        w[10:8]  = e.dlv;
        w[7:0]   = e.vec;
        return w;
    endfunction

endpackage

// File: rtl/irde_input_cond.sv
module irde_input_cond
    import irde_pkg::*;
#(
    parameter int NUM_INPUTS = 26,
    parameter int NUM_PINS   = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] irq_in,
    input  logic [NUM_PINS-1:0]   inv,
    output logic [NUM_PINS-1:0]   act,
    output logic [NUM_PINS-1:0]   rise
);
    logic [NUM_INPUTS-1:0] line_sync;
    logic [NUM_INPUTS-1:0] dropped_unused;
    logic [NUM_PINS-1:0]   pin_raw;
    logic [NUM_PINS-1:0]   act_prev;

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_line
        if (line_to_pin(i) < NUM_PINS) begin : g_kept
            logic s1, s2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= irq_in[i];
                    s2 <= s1;
                end
            end
            assign line_sync[i]      = s2;
            assign dropped_unused[i] = 1'b0;
        end else begin : g_drop
            assign line_sync[i]      = 1'b0;
            assign dropped_unused[i] = irq_in[i];
        end
    end

    always_comb begin
        pin_raw = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int i = 0; i < NUM_INPUTS; i++) begin
                if (line_to_pin(i) == p) pin_raw[p] = pin_raw[p] | line_sync[i];
            end
        end
    end

    assign act  = pin_raw ^ inv;
    assign rise = act & ~act_prev;

    always_ff @(posedge clk) begin
        if (rst) act_prev <= '0;
        else     act_prev <= act;
    end
endmodule

// File: rtl/irde_redir_table.sv
module irde_redir_table
    import irde_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [63:0]        wr_data,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector,
    output redir_t             tbl [NUM_PINS]
);
    redir_t wr_fields;
    logic   wr_unused;

    always_comb begin
        wr_fields.dest   = wr_data[63:56];
        wr_fields.mask   = wr_data[16];
        wr_fields.level  = wr_data[15];
        wr_fields.racked = 1'b0;
        wr_fields.inv    = wr_data[13];
        wr_fields.dmode  = wr_data[11];
        wr_fields.dlv    = wr_data[10:8];
        wr_fields.vec    = wr_data[7:0];
    end
    assign wr_unused = ^{wr_data[55:17], wr_data[14], wr_data[12]};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
        redir_t nxt;
        always_comb begin
            nxt = tbl[p];
            if (wr_en && wr_idx == IDX_W'(p)) begin
                nxt        = wr_fields;
                nxt.racked = tbl[p].racked;
            end
            if (eoi_valid && tbl[p].racked && tbl[p].vec == eoi_vector)
                nxt.racked = 1'b0;
            if (set_en && set_idx == IDX_W'(p))
                nxt.racked = 1'b1;
        end
        always_ff @(posedge clk) begin
            if (rst) tbl[p] <= ENTRY_RESET;
            else     tbl[p] <= nxt;
        end
    end
endmodule

// File: rtl/irde_pick_lowest.sv
module irde_pick_lowest #(
    parameter int N     = 24,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
    import irde_pkg::*;
#(
    parameter int NUM_PINS   = 24,
    parameter int NUM_INPUTS = 26,
    localparam int IDX_W     = $clog2(NUM_PINS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] irq_in,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [63:0]           cfg_wdata,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [63:0]           rd_data,
    input  logic                  eoi_valid,
    input  logic [7:0]            eoi_vector,
    input  logic [7:0]            ext_vector,
    output logic                  msg_valid,
    input  logic                  msg_ready,
    output logic [7:0]            msg_dest,
    output logic                  msg_dest_mode,
    output logic [2:0]            msg_deliv_mode,
    output logic [7:0]            msg_vector,
    output logic                  msg_trig
);
    redir_t             tbl [NUM_PINS];
    logic [NUM_PINS-1:0] mask_v, level_v, racked_v, inv_v;
    logic [NUM_PINS-1:0] act_v, rise_v;
    logic [NUM_PINS-1:0] pend_q, pend_d, eligible;
    logic               found;
    logic [IDX_W-1:0]   sel_idx;
    logic               load;
    redir_t             sel;
    msg_t               msg_q;
    logic               valid_q;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            mask_v[p]   = tbl[p].mask;
            level_v[p]  = tbl[p].level;
            racked_v[p] = tbl[p].racked;
            inv_v[p]    = tbl[p].inv;
        end
    end

    irde_input_cond #(.NUM_INPUTS(NUM_INPUTS), .NUM_PINS(NUM_PINS)) u_cond (
        .clk(clk), .rst(rst), .irq_in(irq_in), .inv(inv_v),
        .act(act_v), .rise(rise_v)
    );

    assign eligible = pend_q & ~mask_v & ~(level_v & racked_v);

    irde_pick_lowest #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
        .req(eligible), .found(found), .idx(sel_idx)
    );

    assign sel  = tbl[sel_idx];
    assign load = found && (!valid_q || msg_ready);

    irde_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
        .set_en(load && sel.level), .set_idx(sel_idx),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .tbl(tbl)
    );

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            if (level_v[p]) begin
                pend_d[p] = act_v[p];
            end else begin
                pend_d[p] = (pend_q[p] && !(load && sel_idx == IDX_W'(p)))
                          || (rise_v[p] && !mask_v[p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (load) begin
            valid_q     <= 1'b1;
            msg_q.dest  <= sel.dest;
            msg_q.dmode <= sel.dmode;
            msg_q.dlv   <= sel.dlv;
            msg_q.vec   <= (sel.dlv == DLV_PASS) ? ext_vector : sel.vec;
            msg_q.level <= sel.level;
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid      = valid_q;
    assign msg_dest       = msg_q.dest;
    assign msg_dest_mode  = msg_q.dmode;
    assign msg_deliv_mode = msg_q.dlv;
    assign msg_vector     = msg_q.vec;
    assign msg_trig       = msg_q.level;

    always_comb begin
        if (32'(rd_idx) < NUM_PINS) rd_data = pack_entry(tbl[rd_idx], pend_q[rd_idx]);
        else                        rd_data = '0;
    end
endmodule

// File: rtl/irde_checker.sv
module irde_checker #(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [7:0]          msg_dest,
    input logic                msg_dest_mode,
    input logic [2:0]          msg_deliv_mode,
    input logic [7:0]          msg_vector,
    input logic                msg_trig,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] rise,
    input logic [NUM_PINS-1:0] mask_v,
    input logic [NUM_PINS-1:0] level_v,
    input logic [NUM_PINS-1:0] racked_v,
    input logic [NUM_PINS-1:0] eligible,
    input logic                load,
    input logic [IDX_W-1:0]    sel_idx
);
    logic [NUM_PINS-1:0] below_sel;
    assign below_sel = (NUM_PINS'(1) << sel_idx) - NUM_PINS'(1);

    // R1: first cycle out of reset is idle
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend == '0 && !msg_valid));

    // R12: stalled message holds
    p_msg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
            && $stable(msg_dest) && $stable(msg_dest_mode)
            && $stable(msg_deliv_mode) && $stable(msg_trig)));

    // R9: a loaded level pin is blocked by remote-acknowledge next cycle
    p_level_block_r9: assert property (@(posedge clk) disable iff (rst)
        (load && level_v[sel_idx]) |=> racked_v[$past(sel_idx)]);

    // R5: masked edge request on an idle edge pin is dropped
    p_masked_edge_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(rise & mask_v & ~level_v & ~pend)) == '0));

    // R11: nothing eligible below the served pin
    p_lowest_first_r11: assert property (@(posedge clk) disable iff (rst)
        load |-> ((eligible & below_sel) == '0));
endmodule

bind irq_redirect_engine irde_checker #(.NUM_PINS(NUM_PINS)) u_irde_chk (
    .clk(clk), .rst(rst),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv_mode(msg_deliv_mode),
    .msg_vector(msg_vector), .msg_trig(msg_trig),
    .pend(pend_q), .rise(rise_v), .mask_v(mask_v), .level_v(level_v),
    .racked_v(racked_v), .eligible(eligible), .load(load), .sel_idx(sel_idx)
);

// File: tb/tb_irq_redirect_engine.sv
module tb_irq_redirect_engine;
    localparam int NP = 24;
    localparam int NI = 26;
    localparam int IW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [63:0]   cfg_wdata = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [63:0]   rd_data;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic [7:0]    ext_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [7:0]    msg_dest;
    logic          msg_dest_mode;
    logic [2:0]    msg_deliv_mode;
    logic [7:0]    msg_vector;
    logic          msg_trig;

    int checks = 0;
    int errors = 0;
    logic [20:0] expq[$];
    string cur_tag = "R7";

    always #5 clk = ~clk;

    irq_redirect_engine #(.NUM_PINS(NP), .NUM_INPUTS(NI)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .ext_vector(ext_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_dest_mode(msg_dest_mode), .msg_deliv_mode(msg_deliv_mode),
        .msg_vector(msg_vector), .msg_trig(msg_trig)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each accepted message is compared with the queue head
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            logic [20:0] got;
            got = {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_trig};
            if (expq.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected message"}, 64'(got), 64'h0);
            end else begin
                logic [20:0] exp;
                exp = expq.pop_front();
                check(got == exp, {cur_tag, " message fields"}, 64'(got), 64'(exp));
            end
        end
    end

    task automatic expect_msg(input logic [7:0] dest, input logic dm, input logic [2:0] dlv,
                              input logic [7:0] vec, input logic lvl);
        expq.push_back({dest, dm, dlv, vec, lvl});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_entry(input int idx, input logic [63:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic read_check(input int idx, input logic [63:0] exp, input string tag);
        @(posedge clk); #1;
        rd_idx = IW'(idx);
        @(negedge clk);
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic pulse(input int line);
        @(posedge clk); #1;
        irq_in[line] = 1'b1;
        step(4);
        irq_in[line] = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(posedge clk); #1;
        eoi_valid = 1'b1; eoi_vector = v;
        @(posedge clk); #1;
        eoi_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        step(25);
        @(negedge clk);
        check(expq.size() == 0, {tag, " expected messages delivered"}, 64'(expq.size()), 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(msg_valid == 1'b0, "R1 msg_valid", 64'(msg_valid), 64'h0);
        for (int p = 0; p < NP; p++) read_check(p, 64'h0000_0000_0001_0000, "R1 entry reset");

        // R2: layout, hardware-owned and reserved bits, out-of-range write index
        cur_tag = "R2";
        write_entry(5, 64'hAB00_0100_0000_593C);
        read_check(5, 64'hAB00_0000_0000_093C, "R2 entry readback");
        write_entry(27, 64'h0000_0000_0000_00FF);
        read_check(0, 64'h0000_0000_0001_0000, "R2 out-of-range write ignored");

        // R5/R7/R9: held edge line gives one message with entry fields
        cur_tag = "R7";
        expect_msg(8'hAB, 1'b1, 3'd1, 8'h3C, 1'b0);
        @(posedge clk); #1; irq_in[5] = 1'b1;
        step(30);
        irq_in[5] = 1'b0;
        drain("R9 edge once");
        read_check(5, 64'hAB00_0000_0000_093C, "R9 edge pending cleared");

        // R3: input mapping
        cur_tag = "R3";
        write_entry(0, 64'h0000_0000_0000_0020);
        write_entry(2, 64'h0000_0000_0000_0022);
        expect_msg(8'h00, 1'b0, 3'd0, 8'h22, 1'b0);
        pulse(0);
        drain("R3 input 0 to pin 2");
        expect_msg(8'h00, 1'b0, 3'd0, 8'h22, 1'b0);
        pulse(2);
        drain("R3 input 2 to pin 2");
        pulse(24);
        pulse(25);
        drain("R3 out-of-range inputs");

        // R5: masked edge discarded
        cur_tag = "R5";
        write_entry(6, 64'h0000_0000_0001_0036);
        pulse(6);
        step(10);
        write_entry(6, 64'h0000_0000_0000_0036);
        drain("R5 masked edge");
        read_check(6, 64'h0000_0000_0000_0036, "R5 no pending after masked edge");

        // R4: inverted polarity, falling line is the request
        cur_tag = "R4";
        write_entry(7, 64'h0000_0000_0001_2047);
        @(posedge clk); #1; irq_in[7] = 1'b1;
        step(6);
        write_entry(7, 64'h0000_0000_0000_2047);
        drain("R4 idle inverted line");
        expect_msg(8'h00, 1'b0, 3'd0, 8'h47, 1'b0);
        @(posedge clk); #1; irq_in[7] = 1'b0;
        drain("R4 falling line delivers");

        // R6/R9/R10: level pin flow
        cur_tag = "R6";
        write_entry(9, 64'h0300_0000_0001_8059);
        @(posedge clk); #1; irq_in[9] = 1'b1;
        step(10);
        read_check(9, 64'h0300_0000_0001_9059, "R6 masked level pending");
        expect_msg(8'h03, 1'b0, 3'd0, 8'h59, 1'b1);
        write_entry(9, 64'h0300_0000_0000_8059);
        drain("R6 unmask delivers once");
        cur_tag = "R9";
        step(20);
        read_check(9, 64'h0300_0000_0000_D059, "R9 remote-ack set, no redelivery");
        cur_tag = "R10";
        eoi(8'h58);
        drain("R10 non-matching notice");
        read_check(9, 64'h0300_0000_0000_D059, "R10 non-matching keeps flag");
        expect_msg(8'h03, 1'b0, 3'd0, 8'h59, 1'b1);
        eoi(8'h59);
        drain("R10 matching notice redelivers");
        @(posedge clk); #1; irq_in[9] = 1'b0;
        step(5);
        read_check(9, 64'h0300_0000_0000_C059, "R6 release clears pending");
        eoi(8'h59);
        drain("R10 notice after release");
        read_check(9, 64'h0300_0000_0000_8059, "R10 flag cleared");

        // R8: pass-through vector
        cur_tag = "R8";
        ext_vector = 8'hE5;
        write_entry(11, 64'h0000_0000_0000_0711);
        expect_msg(8'h00, 1'b0, 3'd7, 8'hE5, 1'b0);
        pulse(11);
        drain("R8 external vector");

        // R11/R12: stalled fabric, two simultaneous edges
        cur_tag = "R11";
        write_entry(12, 64'h0000_0000_0000_006C);
        write_entry(13, 64'h0000_0000_0000_006D);
        @(posedge clk); #1;
        msg_ready = 1'b0;
        irq_in[12] = 1'b1; irq_in[13] = 1'b1;
        step(10);
        @(negedge clk);
        check(msg_valid == 1'b1, "R12 valid while stalled", 64'(msg_valid), 64'h1);
        check(msg_vector == 8'h6C, "R11 lowest pin first", 64'(msg_vector), 64'h6C);
        step(4);
        @(negedge clk);
        check(msg_valid && msg_vector == 8'h6C, "R12 message held", 64'(msg_vector), 64'h6C);
        expect_msg(8'h00, 1'b0, 3'd0, 8'h6C, 1'b0);
        expect_msg(8'h00, 1'b0, 3'd0, 8'h6D, 1'b0);
        @(posedge clk); #1;
        msg_ready = 1'b1;
        irq_in[12] = 1'b0; irq_in[13] = 1'b0;
        drain("R11 both delivered in order");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule